// File: doc/BRIEF.md
# Pseudo-Channel Request Admission Router

The router sits between a single upstream request port and the two pseudo-channel queues of a memory channel. For every request it receives an address, a byte size and a read/write flag. It picks the pseudo-channel from one interleave address bit. It works out how many memory bursts the request covers, given its offset within a burst. It then decides in the same cycle whether the selected channel's half of the read or write buffer budget can take those bursts.

An accepted request completes with a valid/ready handshake. One cycle later it appears as an enqueue strobe toward the chosen channel, carrying the original address, the direction and the burst count. A refused request raises a refuse indication and is not enqueued. It also sets a sticky retry flag for that channel and direction. The flag is released with a one-cycle retry pulse once the matching occupancy leaves room for at least one burst.

The block keeps per-channel occupancy counts for the read queue, the response queue and the write queue. It updates them from its own enqueues and from dequeue strobes returned by the queues. It also derives a per-channel write-drain indication with hysteresis from the write occupancy.

Top module: `pc_admit_router`

## Requirements
- R1: Address bit `SEL_BIT` (default 6) selects the channel: 0 steers an accepted request to channel 0 (`enq_valid` = 2'b01), 1 to channel 1 (`enq_valid` = 2'b10); at most one bit of `enq_valid` is ever high.
- R2: On the clock edge after an accepted non-zero-size request, `enq_valid` is high for one cycle. `enq_addr` carries the request address, `enq_write` the direction, and `enq_bursts` = ceil(((addr mod BURST_BYTES) + size) / BURST_BYTES).
- R3: A write is accepted (`req_ready` high in the same cycle) exactly when the channel's write occupancy plus the burst count is at most WR_BUF/2; occupancy equal to the limit after acceptance is allowed, one more is refused.
- R4: A read is accepted exactly when the channel's read occupancy plus its response occupancy plus the burst count is at most RD_BUF/2.
- R5: A refused request (`req_valid` high, `req_ready` low, `req_refuse` high) is not enqueued. It sets the retry flag of its channel and direction, and the flag stays set while that occupancy leaves no room for one burst.
- R6: When a set retry flag sees room for at least one burst, it clears on the next edge and the matching retry pulse is high for exactly that one cycle.
- R7: Each accepted request adds its burst count to its channel's read or write occupancy. `wr_deq[c]` removes one write entry, `rd_deq[c]` moves one entry from the read count to the response count, and `resp_deq[c]` removes one response entry.
- R8: A zero-size request is consumed (`req_ready` high, `req_refuse` low) with no enqueue, no occupancy change and no retry flag.
- R9: `wr_drain[c]` rises on the edge after the write occupancy is at or above DRAIN_HI_PCT percent of WR_BUF/2. It falls on the edge after the occupancy is at or below DRAIN_LO_PCT percent, and holds in between.
- R10: After reset all occupancies are zero, and no enqueue, flag, pulse or drain output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Request accepted this cycle (when valid) |
| req_refuse | output | 1 | Request refused this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | SIZE_W | Request size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| enq_valid | output | 2 | One-hot enqueue strobe per channel |
| enq_write | output | 1 | Direction of the enqueued request |
| enq_addr | output | ADDR_W | Address of the enqueued request |
| enq_bursts | output | BCNT_W | Burst count of the enqueued request |
| rd_deq | input | 2 | Per channel: one read entry moved to response queue |
| resp_deq | input | 2 | Per channel: one response entry retired |
| wr_deq | input | 2 | Per channel: one write entry retired |
| rd_retry_flag | output | 2 | Sticky read retry flag per channel |
| wr_retry_flag | output | 2 | Sticky write retry flag per channel |
| rd_retry_pulse | output | 2 | One-cycle read retry release per channel |
| wr_retry_pulse | output | 2 | One-cycle write retry release per channel |
| wr_drain | output | 2 | Write drain indication per channel |

## Verification
The bench fills one channel's write share to exactly its limit and then offers one burst more. A design with an off-by-one compare would either refuse the last legal write or accept the overflowing one. It fills the read share partly through entries moved to the response count, so a design that ignored pending responses would accept a read it must refuse. It releases retry flags one entry at a time to catch a pulse that arrives late, lasts two cycles or fires without a prior refusal. It also sends offset-straddling and zero-size requests, and walks the write count through both drain thresholds to expose a missing hysteresis or a wrong burst rounding.

// File: rtl/pc_admit_router.sv
module pc_admit_router #(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 8,
  parameter int BURST_BYTES  = 32,
  parameter int SEL_BIT      = 6,
  parameter int RD_BUF       = 32,
  parameter int WR_BUF       = 32,
  parameter int DRAIN_HI_PCT = 75,
  parameter int DRAIN_LO_PCT = 25,
  localparam int OFF_W       = $clog2(BURST_BYTES),
  localparam int MAX_BURSTS  = ((2**SIZE_W) - 1 + 2*(BURST_BYTES - 1)) / BURST_BYTES,
  localparam int BCNT_W      = $clog2(MAX_BURSTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_refuse,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  output logic [1:0]        enq_valid,
  output logic              enq_write,
  output logic [ADDR_W-1:0] enq_addr,
  output logic [BCNT_W-1:0] enq_bursts,
  input  logic [1:0]        rd_deq,
  input  logic [1:0]        resp_deq,
  input  logic [1:0]        wr_deq,
  output logic [1:0]        rd_retry_flag,
  output logic [1:0]        wr_retry_flag,
  output logic [1:0]        rd_retry_pulse,
  output logic [1:0]        wr_retry_pulse,
  output logic [1:0]        wr_drain
);

  localparam int RD_HALF = RD_BUF / 2;
  localparam int WR_HALF = WR_BUF / 2;
  localparam int WR_HI   = (WR_HALF * DRAIN_HI_PCT) / 100;
  localparam int WR_LO   = (WR_HALF * DRAIN_LO_PCT) / 100;
  localparam int OCC_MAX = (RD_HALF > WR_HALF) ? RD_HALF : WR_HALF;
  localparam int OCC_W   = $clog2(OCC_MAX + 1);
  localparam int SUM_W   = ((OCC_W > BCNT_W) ? OCC_W : BCNT_W) + 2;
  localparam int SPAN_W  = ((SIZE_W > OFF_W) ? SIZE_W : OFF_W) + 2;

  logic [SPAN_W-1:0] span;
  logic [BCNT_W-1:0] bursts;
  logic [SUM_W-1:0]  bursts_x;
  logic              sel, zero, fit, accept;
  logic [1:0]        wr_fit, rd_fit, wr_room, rd_room;

  assign span     = SPAN_W'(req_addr[OFF_W-1:0]) + SPAN_W'(req_size) + SPAN_W'(BURST_BYTES - 1);
  assign bursts   = BCNT_W'(span >> OFF_W);
  assign bursts_x = SUM_W'(bursts);
  assign sel      = req_addr[SEL_BIT];
  assign zero     = (req_size == '0);
  assign fit      = req_write ? wr_fit[sel] : rd_fit[sel];

  assign req_ready  = zero | fit;
  assign req_refuse = req_valid & ~req_ready;
  assign accept     = req_valid & ~zero & fit;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [OCC_W-1:0] wr_occ, rd_occ, rs_occ;
    logic [SUM_W-1:0] rd_sum;
    logic             hit, take_wr, take_rd, set_wr, set_rd;
    logic             wf_q, rf_q, wp_q, rp_q, dr_q;

    assign hit     = (sel == 1'(c));
    assign take_wr = accept & hit & req_write;
    assign take_rd = accept & hit & ~req_write;
    assign set_wr  = req_refuse & hit & req_write;
    assign set_rd  = req_refuse & hit & ~req_write;
    assign rd_sum  = SUM_W'(rd_occ) + SUM_W'(rs_occ);

    assign wr_fit[c]  = (SUM_W'(wr_occ) + bursts_x) <= SUM_W'(WR_HALF);
    assign rd_fit[c]  = (rd_sum + bursts_x) <= SUM_W'(RD_HALF);
    assign wr_room[c] = SUM_W'(wr_occ) < SUM_W'(WR_HALF);
    assign rd_room[c] = rd_sum < SUM_W'(RD_HALF);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_occ <= '0;
        rd_occ <= '0;
        rs_occ <= '0;
        wf_q   <= 1'b0;
        rf_q   <= 1'b0;
        wp_q   <= 1'b0;
        rp_q   <= 1'b0;
        dr_q   <= 1'b0;
      end else begin
        wr_occ <= wr_occ + (take_wr ? OCC_W'(bursts) : '0) - OCC_W'(wr_deq[c]);
        rd_occ <= rd_occ + (take_rd ? OCC_W'(bursts) : '0) - OCC_W'(rd_deq[c]);
        rs_occ <= rs_occ + OCC_W'(rd_deq[c]) - OCC_W'(resp_deq[c]);
        wf_q   <= set_wr | (wf_q & ~wr_room[c]);
        rf_q   <= set_rd | (rf_q & ~rd_room[c]);
        wp_q   <= wf_q & wr_room[c] & ~set_wr;
        rp_q   <= rf_q & rd_room[c] & ~set_rd;
        if (wr_occ >= OCC_W'(WR_HI))
          dr_q <= 1'b1;
        else if (wr_occ <= OCC_W'(WR_LO))
          dr_q <= 1'b0;
      end
    end

    assign wr_retry_flag[c]  = wf_q;
    assign rd_retry_flag[c]  = rf_q;
    assign wr_retry_pulse[c] = wp_q;
    assign rd_retry_pulse[c] = rp_q;
    assign wr_drain[c]       = dr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enq_valid  <= 2'b00;
      enq_write  <= 1'b0;
      enq_addr   <= '0;
      enq_bursts <= '0;
    end else begin
      enq_valid <= {accept & sel, accept & ~sel};
      if (accept) begin
        enq_write  <= req_write;
        enq_addr   <= req_addr;
        enq_bursts <= bursts;
      end
    end
  end

endmodule

// File: rtl/pc_admit_router_chk.sv
module pc_admit_router_chk #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 8,
  parameter int SEL_BIT = 6,
  parameter int BCNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_refuse,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic              req_write,
  input logic [1:0]        enq_valid,
  input logic [BCNT_W-1:0] enq_bursts,
  input logic [1:0]        rd_retry_flag,
  input logic [1:0]        wr_retry_flag,
  input logic [1:0]        rd_retry_pulse,
  input logic [1:0]        wr_retry_pulse
);

  AST_ENQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enq_valid)); // R1

  AST_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != '0) |=>
      (enq_valid == ($past(req_addr[SEL_BIT]) ? 2'b10 : 2'b01))); // R1

  AST_ENQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid != 2'b00) |-> $past(req_valid && req_ready && req_size != '0)); // R2

  AST_BURST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid != 2'b00) |-> (enq_bursts != '0)); // R2

  AST_REFUSE_NO_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_refuse) |=> (enq_valid == 2'b00)); // R5

  AST_REFUSE_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_refuse && req_write) |=>
      ($past(req_addr[SEL_BIT]) ? wr_retry_flag[1] : wr_retry_flag[0])); // R5

  AST_REFUSE_RD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_refuse && !req_write) |=>
      ($past(req_addr[SEL_BIT]) ? rd_retry_flag[1] : rd_retry_flag[0])); // R5

  AST_WR_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_retry_pulse & ~($past(wr_retry_flag) & ~wr_retry_flag)) == 2'b00); // R6

  AST_RD_PULSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_retry_pulse & ~($past(rd_retry_flag) & ~rd_retry_flag)) == 2'b00); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_retry_pulse & $past(rd_retry_pulse)) | (wr_retry_pulse & $past(wr_retry_pulse))) == 2'b00); // R6

  AST_ZERO_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == '0) |-> (req_ready && !req_refuse)); // R8

endmodule

bind pc_admit_router pc_admit_router_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEL_BIT(SEL_BIT), .BCNT_W(BCNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_refuse(req_refuse), .req_addr(req_addr), .req_size(req_size),
  .req_write(req_write), .enq_valid(enq_valid), .enq_bursts(enq_bursts),
  .rd_retry_flag(rd_retry_flag), .wr_retry_flag(wr_retry_flag),
  .rd_retry_pulse(rd_retry_pulse), .wr_retry_pulse(wr_retry_pulse)
);

// File: tb/pc_admit_router_tb_top.sv
module pc_admit_router_tb_top;
  localparam int BW   = $clog2(((2**8) - 1 + 2*31) / 32 + 1);
  localparam int HALF = 16;
  localparam int HI   = 12;
  localparam int LO   = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_refuse, req_write, enq_write;
  logic [31:0] req_addr, enq_addr;
  logic [7:0]  req_size;
  logic [1:0]  enq_valid, rd_deq, resp_deq, wr_deq;
  logic [BW-1:0] enq_bursts;
  logic [1:0]  rd_retry_flag, wr_retry_flag, rd_retry_pulse, wr_retry_pulse, wr_drain;

  pc_admit_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_refuse(req_refuse), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .enq_valid(enq_valid), .enq_write(enq_write),
    .enq_addr(enq_addr), .enq_bursts(enq_bursts), .rd_deq(rd_deq),
    .resp_deq(resp_deq), .wr_deq(wr_deq), .rd_retry_flag(rd_retry_flag),
    .wr_retry_flag(wr_retry_flag), .rd_retry_pulse(rd_retry_pulse),
    .wr_retry_pulse(wr_retry_pulse), .wr_drain(wr_drain)
  );

  int nchk = 0;
  int nerr = 0;
  int m_wr[2], m_rd[2], m_rs[2];
  bit m_wf[2], m_rf[2], m_wp[2], m_rp[2], m_dr[2];

  task automatic chk(string tag, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int nb(logic [31:0] a, int sz);
    return (int'(a % 32) + sz + 31) / 32;
  endfunction

  task automatic step(bit v, logic [31:0] a, int sz, bit w,
                      bit [1:0] rdd, bit [1:0] rsd, bit [1:0] wrd, string tag);
    int ch, b;
    bit zero, fit, acc, refuse;
    int n_wr[2], n_rd[2], n_rs[2];
    bit n_wf[2], n_rf[2], n_wp[2], n_rp[2], n_dr[2];
    req_valid = v; req_addr = a; req_size = sz[7:0]; req_write = w;
    rd_deq = rdd; resp_deq = rsd; wr_deq = wrd;
    #1;
    ch   = int'(a[6]);
    zero = (sz == 0);
    b    = zero ? 0 : nb(a, sz);
    fit  = w ? (m_wr[ch] + b <= HALF) : (m_rd[ch] + m_rs[ch] + b <= HALF);
    if (tag == "") tag = zero ? "R8" : (w ? "R3" : "R4");
    if (v) begin
      chk(tag, "req_ready", req_ready, zero | fit);
      chk(tag, "req_refuse", req_refuse, !(zero | fit));
    end
    acc    = v && !zero && fit;
    refuse = v && !(zero | fit);
    for (int c = 0; c < 2; c++) begin
      bit room_w, room_r, sw, sr;
      room_w = m_wr[c] < HALF;
      room_r = (m_rd[c] + m_rs[c]) < HALF;
      sw = refuse && w && (ch == c);
      sr = refuse && !w && (ch == c);
      n_wf[c] = sw | (m_wf[c] & !room_w);
      n_rf[c] = sr | (m_rf[c] & !room_r);
      n_wp[c] = m_wf[c] & room_w & !sw;
      n_rp[c] = m_rf[c] & room_r & !sr;
      n_dr[c] = (m_wr[c] >= HI) ? 1'b1 : ((m_wr[c] <= LO) ? 1'b0 : m_dr[c]);
      n_wr[c] = m_wr[c] + ((acc && w && ch == c) ? b : 0) - int'(wrd[c]);
      n_rd[c] = m_rd[c] + ((acc && !w && ch == c) ? b : 0) - int'(rdd[c]);
      n_rs[c] = m_rs[c] + int'(rdd[c]) - int'(rsd[c]);
    end
    @(posedge clk);
    #1;
    chk("R1", "enq_valid", enq_valid, acc ? (ch == 1 ? 2 : 1) : 0);
    if (acc) begin
      chk("R2", "enq_bursts", enq_bursts, b);
      chk("R2", "enq_addr", enq_addr, a);
      chk("R2", "enq_write", enq_write, w);
    end
    for (int c = 0; c < 2; c++) begin
      chk("R5", "wr_retry_flag", wr_retry_flag[c], n_wf[c]);
      chk("R5", "rd_retry_flag", rd_retry_flag[c], n_rf[c]);
      chk("R6", "wr_retry_pulse", wr_retry_pulse[c], n_wp[c]);
      chk("R6", "rd_retry_pulse", rd_retry_pulse[c], n_rp[c]);
      chk("R9", "wr_drain", wr_drain[c], n_dr[c]);
      m_wr[c] = n_wr[c]; m_rd[c] = n_rd[c]; m_rs[c] = n_rs[c];
      m_wf[c] = n_wf[c]; m_rf[c] = n_rf[c]; m_wp[c] = n_wp[c];
      m_rp[c] = n_rp[c]; m_dr[c] = n_dr[c];
    end
    @(negedge clk);
  endtask

  task automatic idle(bit [1:0] rdd, bit [1:0] rsd, bit [1:0] wrd, string tag);
    step(1'b0, 32'h0, 0, 1'b0, rdd, rsd, wrd, tag);
  endtask

  task automatic drain_all(string tag);
    while (m_wr[0] + m_wr[1] + m_rd[0] + m_rd[1] + m_rs[0] + m_rs[1] > 0) begin
      bit [1:0] rdd, rsd, wrd;
      for (int c = 0; c < 2; c++) begin
        rdd[c] = m_rd[c] > 0;
        rsd[c] = m_rs[c] > 0;
        wrd[c] = m_wr[c] > 0;
      end
      idle(rdd, rsd, wrd, tag);
    end
    repeat (3) idle(2'b00, 2'b00, 2'b00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_size = 0; req_write = 0;
    rd_deq = 0; resp_deq = 0; wr_deq = 0;
    for (int c = 0; c < 2; c++) begin
      m_wr[c] = 0; m_rd[c] = 0; m_rs[c] = 0;
      m_wf[c] = 0; m_rf[c] = 0; m_wp[c] = 0; m_rp[c] = 0; m_dr[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10", "enq_valid", enq_valid, 0);
    chk("R10", "flags", {rd_retry_flag, wr_retry_flag}, 0);
    chk("R10", "pulses", {rd_retry_pulse, wr_retry_pulse}, 0);
    chk("R10", "wr_drain", wr_drain, 0);
    @(negedge clk);

    // R10: empty after reset, a maximal request fits
    step(1, 32'h0000_001F, 255, 1, 0, 0, 0, "R10");
    drain_all("R7");

    // R2: offset straddling bursts, R1: steering by bit 6
    step(1, 32'h0000_001F, 2, 1, 0, 0, 0, "R2");
    step(1, 32'h0000_007F, 64, 0, 0, 0, 0, "R2");
    step(1, 32'h0000_0040, 32, 1, 0, 0, 0, "R1");
    step(1, 32'h0000_0020, 1, 0, 0, 0, 0, "R1");
    drain_all("R7");

    // R3: write share filled to exactly the limit, then one more
    for (int i = 0; i < HALF; i++) step(1, 32'h0000_0000, 32, 1, 0, 0, 0, "R3");
    step(1, 32'h0000_0000, 32, 1, 0, 0, 0, "R3");
    step(1, 32'h0000_0040, 32, 1, 0, 0, 0, "R3");
    repeat (3) idle(0, 0, 0, "R5");
    idle(0, 0, 2'b01, "R6");
    repeat (2) idle(0, 0, 0, "R6");
    while (m_wr[0] > 0) idle(0, 0, 2'b01, "R9");
    drain_all("R9");

    // R4/R7: read share counting response entries
    for (int i = 0; i < 8; i++) step(1, 32'h0000_0040, 32, 0, 0, 0, 0, "R4");
    repeat (8) idle(2'b10, 0, 0, "R7");
    for (int i = 0; i < 8; i++) step(1, 32'h0000_0040, 32, 0, 0, 0, 0, "R7");
    step(1, 32'h0000_0040, 32, 0, 0, 0, 0, "R4");
    step(1, 32'h0000_0040, 0, 0, 0, 0, 0, "R8");
    step(1, 32'h0000_0000, 32, 0, 0, 0, 0, "R4");
    idle(0, 2'b10, 0, "R6");
    repeat (2) idle(0, 0, 0, "R6");
    drain_all("R7");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v, w;
      int sz;
      logic [31:0] a;
      bit [1:0] rdd, rsd, wrd;
      v  = ($urandom % 10) < 7;
      w  = $urandom % 2;
      a  = $urandom;
      sz = (($urandom % 16) == 0) ? 0 : int'($urandom % 256);
      for (int c = 0; c < 2; c++) begin
        rdd[c] = (m_rd[c] > 0) && (($urandom % 3) == 0);
        rsd[c] = (m_rs[c] > 0) && (($urandom % 3) == 0);
        wrd[c] = (m_wr[c] > 0) && (($urandom % 3) == 0);
      end
      step(v, a, sz, w, rdd, rsd, wrd, "");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule